// File: doc/BRIEF.md
# JTAG Source Switch Controller

This block decides which of two JTAG masters drives a single downstream TAP controller. One master is the set of dedicated external JTAG pins. The other is an internal scan engine run by the processor. After a cold reset the external pins own the TAP. Software picks the source by writing a control register that holds a source-select bit and a separate chain-enable bit. The internal engine is requested only when both bits are set.

A change of source is never applied at once. The request waits until both TCK inputs have been low for two consecutive system-clock samples. While it waits, the TAP sees TCK held low and TMS held high. When the internal engine is connected, the block drives an automatic active-low TAP reset of fixed length. The TDO returned from the TAP goes only to the master that is connected.

The state machine has four states:
- `ST_EXT`: the external pins are connected.
- `ST_INT`: the internal engine is connected.
- `ST_WAIT`: a switch is pending.
- `ST_RST`: the reset pulse that follows a connect is being driven.

Its transitions:
- `ST_EXT`→`ST_WAIT` when the internal engine is requested.
- `ST_INT`→`ST_WAIT` when that request is withdrawn.
- `ST_WAIT`→`ST_RST` when both clocks are idle and the internal engine is requested.
- `ST_WAIT`→`ST_EXT` when both clocks are idle and the external pins are requested.
- `ST_WAIT`→`ST_EXT` or `ST_INT` (the current source) when the request is withdrawn before the switch happens.
- `ST_RST`→`ST_INT` when the pulse count is reached.

Top module: `jtag_src_switch`

## Requirements
- R1: After reset, the external pins drive the TAP. The status register reads 0 and the control register reads 0.
- R2: Register address 0 is the control register, with bit 0 = source select and bit 1 = chain enable. It reads back what was written. Address 1 is the status register, with bit 0 = internal engine active, bit 1 = switch pending and bit 2 = reset pulse in progress. Writes to address 1 have no effect.
- R3: The internal engine becomes the source only when both control bits are 1. Any other control value selects the external pins.
- R4: A requested change stays pending until both TCK inputs, after a 2-stage synchronizer, have been sampled low on 2 consecutive system clocks. A single-cycle low does not complete a switch.
- R5: While a switch is pending, tap_tck is 0 and tap_tms is 1, whatever either master drives.
- R6: If the request returns to the current source while a switch is pending, the pending state clears and no switch takes place.
- R7: On a connect to the internal engine, tap_trst_n is held low for exactly 4 system-clock cycles and tap_tck is held low during that time.
- R8: tap_tdo is passed to the TDO output of the connected master. The TDO output of the other master reads 1.
- R9: While the internal engine is connected, the external TCK and TRST inputs have no effect on the TAP outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low cold reset, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 control, 1 status) |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 3 | Register read data, combinational |
| ext_tck | input | 1 | External pin TCK |
| ext_tms | input | 1 | External pin TMS |
| ext_tdi | input | 1 | External pin TDI |
| ext_trst_n | input | 1 | External pin TAP reset, active low |
| ext_tdo | output | 1 | TDO returned to the external pins |
| int_tck | input | 1 | Internal engine TCK |
| int_tms | input | 1 | Internal engine TMS |
| int_tdi | input | 1 | Internal engine TDI |
| int_trst_n | input | 1 | Internal engine TAP reset, active low |
| int_tdo | output | 1 | TDO returned to the internal engine |
| tap_tck | output | 1 | TCK to the target TAP |
| tap_tms | output | 1 | TMS to the target TAP |
| tap_tdi | output | 1 | TDI to the target TAP |
| tap_trst_n | output | 1 | TAP reset to the target, active low |
| tap_tdo | input | 1 | TDO from the target TAP |

## Verification
The hardest case to reach from the ports is a pending switch that sees brief, single-cycle idle windows on both clocks and must still not complete. The stimulus first raises both TCK inputs and then writes the request. It then lowers both clocks together for exactly one system cycle at a time, several times over, and checks that the pending bit survives each window. A steady low then completes the switch. The bench counts, cycle by cycle, how long tap_trst_n stays low. It raises the internal TCK during the pulse to show that the forced-low clock holds.

// File: rtl/jsw_pkg.sv
package jsw_pkg;

    typedef enum logic [1:0] {
        ST_EXT  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RST  = 2'd2,
        ST_INT  = 2'd3
    } jsw_state_e;

    localparam int CTRL_W     = 2;
    localparam int STAT_W     = 3;
    localparam int CTRL_SEL   = 0;
    localparam int CTRL_CHAIN = 1;
    localparam int STAT_ACT   = 0;
    localparam int STAT_PEND  = 1;
    localparam int STAT_RST   = 2;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

endpackage

// File: rtl/jsw_sync.sv
module jsw_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/jsw_idle.sv
module jsw_idle #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tck_i,
    input  logic int_tck_i,
    output logic idle_o
);

    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

    logic [1:0]       tck_s;
    logic [CNT_W-1:0] low_cnt_q;
    logic             both_low;

    jsw_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({int_tck_i, ext_tck_i}),
        .q_o   (tck_s)
    );

    assign both_low = (tck_s == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!both_low) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_MAX) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign idle_o = (low_cnt_q == CNT_MAX);

    AST_IDLE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> $past(both_low)) else $error("idle without low sample"); // R4

endmodule

// File: rtl/jsw_regs.sv
module jsw_regs
    import jsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              active_i,
    input  logic              pending_i,
    input  logic              rst_busy_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic              req_int_o
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_i && addr_i == ADDR_CTRL) begin
            ctrl_q <= wdata_i;
        end
    end

    always_comb begin
        stat            = '0;
        stat[STAT_ACT]  = active_i;
        stat[STAT_PEND] = pending_i;
        stat[STAT_RST]  = rst_busy_i;
    end

    assign rdata_o   = (addr_i == ADDR_STAT) ? stat : STAT_W'(ctrl_q);
    assign req_int_o = ctrl_q[CTRL_SEL] & ctrl_q[CTRL_CHAIN];

    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_STAT) |=> $stable(ctrl_q)) else $error("status write"); // R2

endmodule

// File: rtl/jsw_fsm.sv
module jsw_fsm
    import jsw_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_int_i,
    input  logic       idle_i,
    output jsw_state_e state_o,
    output logic       active_o
);

    localparam int PC_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CYCLES - 1);

    jsw_state_e state_q, state_d;
    logic       active_q, active_d;
    logic [PC_W-1:0] pcnt_q, pcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_EXT;
            active_q <= 1'b0;
            pcnt_q   <= '0;
        end else begin
            state_q  <= state_d;
            active_q <= active_d;
            pcnt_q   <= pcnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        pcnt_d   = '0;
        unique case (state_q)
            ST_EXT: begin
                if (req_int_i) state_d = ST_WAIT;
            end
            ST_INT: begin
                if (!req_int_i) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (req_int_i == active_q) begin
                    state_d = active_q ? ST_INT : ST_EXT;
                end else if (idle_i) begin
                    active_d = req_int_i;
                    state_d  = req_int_i ? ST_RST : ST_EXT;
                end
            end
            ST_RST: begin
                if (pcnt_q == PC_LAST) begin
                    state_d = ST_INT;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end
            default: state_d = ST_EXT;
        endcase
    end

    assign state_o  = state_q;
    assign active_o = active_q;

    AST_SWITCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> $past(idle_i)) else $error("switch while busy"); // R4
    AST_CONNECT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(req_int_i)) else $error("connect without request"); // R3
    AST_PULSE_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST && $past(state_q) != ST_RST) |-> pcnt_q == '0) else $error("pulse count"); // R7

endmodule

// File: rtl/jtag_src_switch.sv
module jtag_src_switch
    import jsw_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int IDLE_CYCLES  = 2,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              ext_tck,
    input  logic              ext_tms,
    input  logic              ext_tdi,
    input  logic              ext_trst_n,
    output logic              ext_tdo,
    input  logic              int_tck,
    input  logic              int_tms,
    input  logic              int_tdi,
    input  logic              int_trst_n,
    output logic              int_tdo,
    output logic              tap_tck,
    output logic              tap_tms,
    output logic              tap_tdi,
    output logic              tap_trst_n,
    input  logic              tap_tdo
);

    jsw_state_e state;
    logic       active_int;
    logic       req_int;
    logic       idle;
    logic       pending;
    logic       rst_busy;

    jsw_idle #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_CYCLES (IDLE_CYCLES)
    ) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_tck_i (ext_tck),
        .int_tck_i (int_tck),
        .idle_o    (idle)
    );

    jsw_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .active_i   (active_int),
        .pending_i  (pending),
        .rst_busy_i (rst_busy),
        .rdata_o    (reg_rdata),
        .req_int_o  (req_int)
    );

    jsw_fsm #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_int_i (req_int),
        .idle_i    (idle),
        .state_o   (state),
        .active_o  (active_int)
    );

    assign pending  = (state == ST_WAIT);
    assign rst_busy = (state == ST_RST);

    always_comb begin
        tap_tck    = active_int ? int_tck    : ext_tck;
        tap_tms    = active_int ? int_tms    : ext_tms;
        tap_tdi    = active_int ? int_tdi    : ext_tdi;
        tap_trst_n = active_int ? int_trst_n : ext_trst_n;
        if (pending) begin
            tap_tck = 1'b0;
            tap_tms = 1'b1;
        end
        if (rst_busy) begin
            tap_tck    = 1'b0;
            tap_trst_n = 1'b0;
        end
        ext_tdo = active_int ? 1'b1    : tap_tdo;
        int_tdo = active_int ? tap_tdo : 1'b1;
    end

    AST_CONNECT_RESETS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_int) |-> !tap_trst_n) else $error("no reset on connect"); // R7

endmodule

// File: tb/test_jtag_src_switch.sv
module test_jtag_src_switch;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [2:0] reg_rdata;
    logic ext_tck = 1'b0, ext_tms = 1'b0, ext_tdi = 1'b0, ext_trst_n = 1'b1;
    logic int_tck = 1'b0, int_tms = 1'b0, int_tdi = 1'b0, int_trst_n = 1'b1;
    logic ext_tdo, int_tdo;
    logic tap_tck, tap_tms, tap_tdi, tap_trst_n;
    logic tap_tdo = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    jtag_src_switch i_jtag_src_switch (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_tck(ext_tck), .ext_tms(ext_tms), .ext_tdi(ext_tdi), .ext_trst_n(ext_trst_n), .ext_tdo(ext_tdo),
        .int_tck(int_tck), .int_tms(int_tms), .int_tdi(int_tdi), .int_trst_n(int_trst_n), .int_tdo(int_tdo),
        .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_trst_n(tap_trst_n), .tap_tdo(tap_tdo)
    );

    // {ctrl[1:0], ext_tck, int_tck, wait[7:0], status[2:0]}
    localparam logic [14:0] VEC [8] = '{
        {2'b01, 1'b0, 1'b0, 8'd8,  3'b000},  // R3 one bit only
        {2'b11, 1'b1, 1'b1, 8'd8,  3'b010},  // R4 busy clocks
        {2'b11, 1'b0, 1'b1, 8'd8,  3'b010},  // R4 one clock busy
        {2'b11, 1'b0, 1'b0, 8'd12, 3'b001},  // R7 connect
        {2'b10, 1'b1, 1'b0, 8'd8,  3'b011},  // R3 withdraw, busy
        {2'b10, 1'b0, 1'b0, 8'd8,  3'b000},  // R4 back to pins
        {2'b11, 1'b1, 1'b1, 8'd4,  3'b010},  // R6 request
        {2'b00, 1'b1, 1'b1, 8'd4,  3'b000}   // R6 cancel
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [2:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] r;
        int lowc, hic;
        bit seen;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // reset state
        rd(1'b1, r); check("R1 status", r, 0);
        rd(1'b0, r); check("R1 control", r, 0);
        ext_tck = 1'b1; ext_tms = 1'b0; ext_tdi = 1'b1; ext_trst_n = 1'b0; tap_tdo = 1'b0;
        #1;
        check("R1 tck pins", tap_tck, 1);
        check("R1 tms pins", tap_tms, 0);
        check("R1 tdi pins", tap_tdi, 1);
        check("R1 trst pins", tap_trst_n, 0);
        check("R8 ext tdo", ext_tdo, 0);
        check("R8 int tdo", int_tdo, 1);
        ext_trst_n = 1'b1; ext_tck = 1'b0; tap_tdo = 1'b1;

        // table walk
        for (int i = 0; i < 8; i++) begin
            ext_tck = VEC[i][12];
            int_tck = VEC[i][11];
            cycles(4);
            wr(1'b0, VEC[i][14:13]);
            cycles(int'(VEC[i][10:3]));
            rd(1'b1, r);
            check($sformatf("R3/R4/R6/R7 vector %0d", i), r, int'(VEC[i][2:0]));
        end

        // R2 control readback and ignored status write
        rd(1'b0, r); check("R2 control readback", r, 0);
        wr(1'b1, 2'b11);
        cycles(6);
        rd(1'b0, r); check("R2 control after status write", r, 0);
        rd(1'b1, r); check("R2 status after status write", r, 0);

        // R5 pending forces clock low, TMS high
        ext_tck = 1'b1; int_tck = 1'b1; ext_tms = 1'b0;
        cycles(4);
        wr(1'b0, 2'b11);
        cycles(2);
        check("R5 tck held", tap_tck, 0);
        check("R5 tms held", tap_tms, 1);

        // R4 single-cycle idle windows do not complete the switch
        for (int k = 0; k < 5; k++) begin
            ext_tck = 1'b0; int_tck = 1'b0;
            cycles(1);
            ext_tck = 1'b1; int_tck = 1'b1;
            cycles(3);
        end
        rd(1'b1, r); check("R4 glitch still pending", r, 3'b010);

        // R7 reset pulse length and forced clock
        ext_tck = 1'b0; int_tck = 1'b0;
        lowc = 0; hic = 0; seen = 1'b0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            #1;
            if (!tap_trst_n) begin
                lowc++;
                if (tap_tck) hic++;
                if (!seen) begin seen = 1'b1; int_tck = 1'b1; end
            end
        end
        check("R7 pulse length", lowc, 4);
        check("R7 tck during pulse", hic, 0);
        rd(1'b1, r); check("R7 connected status", r, 3'b001);
        check("R3 tck from engine", tap_tck, 1);

        // R8 TDO routing while internal engine connected
        tap_tdo = 1'b0;
        #1;
        check("R8 int tdo follows", int_tdo, 0);
        check("R8 ext tdo idle", ext_tdo, 1);

        // R9 external pins ignored
        int_tck = 1'b0;
        ext_trst_n = 1'b0; ext_tck = 1'b1;
        #1;
        check("R9 trst ignored", tap_trst_n, 1);
        check("R9 tck ignored", tap_tck, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule